// File: doc/BRIEF.md
# Compare-Match Timer Channel Bank

A bank of independent up-counting timer channels behind a single-clock word register bus. Each channel owns a control/status register, a count register and a compare register; one shared start/stop word holds a run bit per channel. A running channel advances its count on a prescaled tick taken from a slow reference clock. That reference clock is presented to the block as a one-cycle tick-enable in the bus clock domain. When the count reaches the compare value at an advance, the channel sets a sticky match flag. In periodic mode the count then restarts from zero.

Software configures a channel by loading its compare value, choosing a count clock and a mode, and setting its run bit. It then either polls the flags or waits for the shared interrupt output. The flags are cleared by writing the control word back with the flag bits at zero. Because the count notionally lives in the reference domain, a write to it lands only after a fixed number of reference ticks, two by default.

Top module: `cmt_bank`

## Requirements
- R1: After reset every count reads 0, every compare reads all ones, every control word reads 0, the start/stop word reads 0 and `irq_o` is 0.
- R2: Word address 0 is the start/stop word, whose bit n runs (1) or stops (0) channel n. Channel n occupies word addresses 4(n+1)+0 (control/status), +1 (count) and +2 (compare). Every other address reads 0.
- R3: Control bits 2:0 select the count clock. Codes 4, 5, 6 and 7 advance a running count once every 8, 32, 128 and 1 reference ticks. Codes 0 to 3 never advance it. After each advance the prescaler phase restarts at zero.
- R4: A stopped channel holds its count and keeps its prescaler phase at zero. All of its registers can still be read and written.
- R5: An advance that finds the count equal to the compare value sets the match flag (control bit 15). If periodic mode (control bit 8) is set, that advance loads 0 into the count instead of incrementing it.
- R6: Without periodic mode the count increments past the compare value. An advance from all ones wraps the count to 0 and sets the overflow flag (control bit 14).
- R7: Writing the control word with a flag bit at 0 clears that flag. Writing it with a 1 leaves the flag unchanged. A flag-setting event in the same cycle as a clearing write leaves the flag set.
- R8: A count write is held pending and is loaded into the count on the second reference tick after the write. Until then the old count reads back and keeps advancing.
- R9: `irq_o` is the OR over channels of: match flag AND control bit 7 AND control bits 5:4 equal to 2. Request type 1 and request type 0 drive no output.
- R10: A compare write takes effect at once and reads back on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock; all state changes on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 1 | One-cycle pulse per reference-clock period |
| bus_wr_i | input | 1 | Write strobe for the addressed word |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | CNT_W | Write data |
| bus_rdata_o | output | CNT_W | Combinational read data of the addressed word |
| irq_o | output | 1 | Shared interrupt request |

## Verification
The bench targets these corner cases:
- The exact edge on which a pending count write lands. A delay off by one shows the new value a cycle early or a cycle late.
- The full-scale wrap. A design that confused the wrap with a periodic clear would miss the overflow flag or zero the count at the compare value.
- The write-zero-to-clear rule. A design that cleared on writing 1 would drop a flag on a harmless write back.
- A match on a channel set for a request type other than interrupt. This catches an interrupt that ignores the request field.
- Each divide code. This exposes a prescaler that counts one tick too many or keeps its phase while stopped.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

   localparam int CTRL_W     = 16;
   localparam int B_MATCH    = 15;
   localparam int B_OVF      = 14;
   localparam int B_PERIODIC = 8;
   localparam int B_IRQEN    = 7;
   localparam int B_REQ_LO   = 4;
   localparam int B_CKS_LO   = 0;

   localparam int SLOT_CTRL  = 0;
   localparam int SLOT_COUNT = 1;
   localparam int SLOT_CMP   = 2;

   localparam int PRESC_W    = 7;
   localparam logic [1:0] REQ_IRQ = 2'd2;

   typedef struct packed {
      logic       periodic;
      logic       irq_en;
      logic [1:0] req;
      logic [2:0] cks;
   } ch_cfg_t;

   // Terminal prescaler phase for a count-clock code.
   function automatic logic [PRESC_W-1:0] presc_last(input logic [2:0] cks);
      case (cks)
         3'd4:    presc_last = PRESC_W'(7);
         3'd5:    presc_last = PRESC_W'(31);
         3'd6:    presc_last = PRESC_W'(127);
         default: presc_last = '0;
      endcase
   endfunction

   function automatic logic cks_counts(input logic [2:0] cks);
      cks_counts = cks[2];
   endfunction

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
   import cmt_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       run_i,
   input  logic       tick_i,
   input  logic [2:0] cks_i,
   output logic       adv_o
);

   logic [PRESC_W-1:0] phase_q;
   logic [PRESC_W-1:0] last;
   logic               at_end;
   logic               active;

   assign last   = presc_last(cks_i);
   assign at_end = (phase_q >= last);
   assign active = run_i && cks_counts(cks_i);
   assign adv_o  = active && tick_i && at_end;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         phase_q <= '0;
      else if (!active)
         phase_q <= '0;
      else if (tick_i)
         phase_q <= at_end ? '0 : phase_q + 1'b1;
   end

   // R4: a stopped channel keeps its prescaler phase at zero
   p_stop_phase_zero_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> (phase_q == '0));

   // R3: after an advance on a dividing code the phase restarts
   p_phase_restart_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (adv_o && cks_i != 3'd7) |=> (phase_q == '0));

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
   import cmt_pkg::*;
#(
   parameter int CNT_W      = 32,
   parameter int LOAD_DELAY = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              run_i,
   input  logic              tick_i,
   input  logic              ctrl_wr_i,
   input  logic              cnt_wr_i,
   input  logic              cmp_wr_i,
   input  logic [CNT_W-1:0]  wdata_i,
   output logic [CTRL_W-1:0] ctrl_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [CNT_W-1:0]  cmp_o,
   output logic              irq_o
);

   localparam int PEND_W = (LOAD_DELAY < 1) ? 1 : $clog2(LOAD_DELAY + 1);

   ch_cfg_t          cfg_q;
   logic             match_q, ovf_q;
   logic [CNT_W-1:0] cnt_q, cmp_q;
   logic             adv, load;
   logic [CNT_W-1:0] load_val;
   logic             hit, full, clr_zero, set_match, set_ovf;

   cmt_prescaler u_presc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run_i),
      .tick_i (tick_i),
      .cks_i  (cfg_q.cks),
      .adv_o  (adv)
   );

   generate
      if (LOAD_DELAY == 0) begin : g_direct
         assign load     = cnt_wr_i;
         assign load_val = wdata_i;
      end else begin : g_delayed
         logic [PEND_W-1:0] pend_q;
         logic [CNT_W-1:0]  pval_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               pend_q <= '0;
               pval_q <= '0;
            end else if (cnt_wr_i) begin
               pend_q <= PEND_W'(LOAD_DELAY);
               pval_q <= wdata_i;
            end else if (tick_i && pend_q != '0) begin
               pend_q <= pend_q - 1'b1;
            end
         end
         assign load     = tick_i && (pend_q == PEND_W'(1));
         assign load_val = pval_q;
      end
   endgenerate

   assign hit       = (cnt_q == cmp_q);
   assign full      = &cnt_q;
   assign clr_zero  = adv && !load && hit && cfg_q.periodic;
   assign set_match = adv && !load && hit;
   assign set_ovf   = adv && !load && full && !clr_zero;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (adv)
         cnt_q <= clr_zero ? '0 : cnt_q + 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         cmp_q <= '1;
      else if (cmp_wr_i)
         cmp_q <= wdata_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cfg_q   <= '0;
         match_q <= 1'b0;
         ovf_q   <= 1'b0;
      end else if (ctrl_wr_i) begin
         match_q        <= (match_q & wdata_i[B_MATCH]) | set_match;
         ovf_q          <= (ovf_q & wdata_i[B_OVF]) | set_ovf;
         cfg_q.periodic <= wdata_i[B_PERIODIC];
         cfg_q.irq_en   <= wdata_i[B_IRQEN];
         cfg_q.req      <= wdata_i[B_REQ_LO +: 2];
         cfg_q.cks      <= wdata_i[B_CKS_LO +: 3];
      end else begin
         match_q <= match_q | set_match;
         ovf_q   <= ovf_q | set_ovf;
      end
   end

   always_comb begin
      ctrl_o                 = '0;
      ctrl_o[B_MATCH]        = match_q;
      ctrl_o[B_OVF]          = ovf_q;
      ctrl_o[B_PERIODIC]     = cfg_q.periodic;
      ctrl_o[B_IRQEN]        = cfg_q.irq_en;
      ctrl_o[B_REQ_LO +: 2]  = cfg_q.req;
      ctrl_o[B_CKS_LO +: 3]  = cfg_q.cks;
   end

   assign cnt_o = cnt_q;
   assign cmp_o = cmp_q;
   assign irq_o = match_q && cfg_q.irq_en && (cfg_q.req == REQ_IRQ);

   // R7: flags are sticky without a control write
   p_match_sticky_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (match_q && !ctrl_wr_i) |=> match_q);
   p_ovf_sticky_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_q && !ctrl_wr_i) |=> ovf_q);

   // R5: periodic clear on a compare match
   p_periodic_clear_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (adv && !load && cfg_q.periodic && (cnt_q == cmp_q)) |=> (cnt_q == '0) && match_q);

   // R4: a stopped channel holds its count unless a pending write lands
   p_stopped_hold_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_i && !load) |=> $stable(cnt_q));

   // R6: a wrap from full scale raises the overflow flag
   p_wrap_ovf_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (adv && !load && !cfg_q.periodic && (&cnt_q)) |=> (cnt_q == '0) && ovf_q);

endmodule

// File: rtl/cmt_bank.sv
module cmt_bank
   import cmt_pkg::*;
#(
   parameter int NUM_CH     = 2,
   parameter int CNT_W      = 32,
   parameter int ADDR_W     = 4,
   parameter int CH_STRIDE  = 4,
   parameter int LOAD_DELAY = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ref_tick_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [CNT_W-1:0]  bus_wdata_i,
   output logic [CNT_W-1:0]  bus_rdata_o,
   output logic              irq_o
);

   localparam int WORDS = (NUM_CH + 1) * CH_STRIDE;

   generate
      if (NUM_CH < 1 || NUM_CH > CNT_W) begin : g_bad_nch
         $error("cmt_bank: NUM_CH out of range");
      end
      if (CNT_W < CTRL_W || CNT_W > 32) begin : g_bad_w
         $error("cmt_bank: CNT_W must lie in 16..32");
      end
      if (CH_STRIDE < 3 || WORDS > (1 << ADDR_W)) begin : g_bad_map
         $error("cmt_bank: address space too small for the channel map");
      end
      if (LOAD_DELAY < 0 || LOAD_DELAY > 15) begin : g_bad_dly
         $error("cmt_bank: LOAD_DELAY out of range");
      end
   endgenerate

   logic [NUM_CH-1:0] start_q;
   logic [NUM_CH-1:0] ch_irq;
   logic [CTRL_W-1:0] ctrl_rd [NUM_CH];
   logic [CNT_W-1:0]  cnt_rd  [NUM_CH];
   logic [CNT_W-1:0]  cmp_rd  [NUM_CH];
   logic              start_wr;

   assign start_wr = bus_wr_i && (bus_addr_i == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         start_q <= '0;
      else if (start_wr)
         start_q <= bus_wdata_i[NUM_CH-1:0];
   end

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CH_STRIDE * (g + 1) + SLOT_CTRL);
      localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(CH_STRIDE * (g + 1) + SLOT_COUNT);
      localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(CH_STRIDE * (g + 1) + SLOT_CMP);

      cmt_channel #(
         .CNT_W      (CNT_W),
         .LOAD_DELAY (LOAD_DELAY)
      ) u_ch (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .run_i     (start_q[g]),
         .tick_i    (ref_tick_i),
         .ctrl_wr_i (bus_wr_i && bus_addr_i == A_CTRL),
         .cnt_wr_i  (bus_wr_i && bus_addr_i == A_CNT),
         .cmp_wr_i  (bus_wr_i && bus_addr_i == A_CMP),
         .wdata_i   (bus_wdata_i),
         .ctrl_o    (ctrl_rd[g]),
         .cnt_o     (cnt_rd[g]),
         .cmp_o     (cmp_rd[g]),
         .irq_o     (ch_irq[g])
      );
   end

   always_comb begin
      bus_rdata_o = '0;
      if (bus_addr_i == '0)
         bus_rdata_o = CNT_W'(start_q);
      for (int i = 0; i < NUM_CH; i++) begin
         if (bus_addr_i == ADDR_W'(CH_STRIDE * (i + 1) + SLOT_CTRL))
            bus_rdata_o = CNT_W'(ctrl_rd[i]);
         if (bus_addr_i == ADDR_W'(CH_STRIDE * (i + 1) + SLOT_COUNT))
            bus_rdata_o = cnt_rd[i];
         if (bus_addr_i == ADDR_W'(CH_STRIDE * (i + 1) + SLOT_CMP))
            bus_rdata_o = cmp_rd[i];
      end
   end

   assign irq_o = |ch_irq;

   // R2: the start/stop word changes only on a write to address 0
   p_start_hold_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !start_wr |=> $stable(start_q));

endmodule

// File: tb/tb_cmt_bank.sv
`timescale 1ns/1ps
module tb_cmt_bank;

   localparam int NCH = 2;
   localparam int W   = 32;
   localparam int AW  = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [W-1:0]  wdata = '0;
   logic [W-1:0]  rdata;
   logic          irq;

   int errors = 0;
   int checks = 0;
   int tick_period = 1;
   int cyc = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   cmt_bank dut (
      .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(tick), .bus_wr_i(wr),
      .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
   );

   // ---------------- reference model ----------------
   bit [NCH-1:0] m_start;
   bit [31:0] m_cnt [NCH], m_cmp [NCH], m_pval [NCH];
   int        m_presc [NCH], m_pend [NCH];
   bit        m_match [NCH], m_ovf [NCH], m_per [NCH], m_ie [NCH];
   bit [1:0]  m_req [NCH];
   bit [2:0]  m_cks [NCH];

   function automatic int last_of(bit [2:0] c);
      case (c)
         3'd4: return 7;
         3'd5: return 31;
         3'd6: return 127;
         default: return 0;
      endcase
   endfunction

   task automatic model_reset();
      m_start = '0;
      for (int i = 0; i < NCH; i++) begin
         m_cnt[i] = 0; m_cmp[i] = 32'hFFFF_FFFF; m_pval[i] = 0;
         m_presc[i] = 0; m_pend[i] = 0;
         m_match[i] = 0; m_ovf[i] = 0; m_per[i] = 0; m_ie[i] = 0;
         m_req[i] = 0; m_cks[i] = 0;
      end
   endtask

   task automatic model_step();
      for (int i = 0; i < NCH; i++) begin
         int base = 4 * (i + 1);
         bit run = m_start[i];
         bit ok = (m_cks[i] >= 4);
         int lst = last_of(m_cks[i]);
         bit adv = run && tick && ok && (m_presc[i] >= lst);
         bit ld = tick && (m_pend[i] == 1);
         bit hit = (m_cnt[i] == m_cmp[i]);
         bit clr = adv && !ld && hit && m_per[i];
         bit sm = adv && !ld && hit;
         bit so = adv && !ld && (m_cnt[i] == 32'hFFFF_FFFF) && !clr;
         if (!run || !ok) m_presc[i] = 0;
         else if (tick) m_presc[i] = (m_presc[i] >= lst) ? 0 : m_presc[i] + 1;
         if (ld) m_cnt[i] = m_pval[i];
         else if (adv) m_cnt[i] = clr ? 0 : m_cnt[i] + 1;
         if (wr && addr == AW'(base + 1)) begin
            m_pend[i] = 2; m_pval[i] = wdata;
         end else if (tick && m_pend[i] != 0) m_pend[i] = m_pend[i] - 1;
         if (wr && addr == AW'(base)) begin
            m_match[i] = (m_match[i] & wdata[15]) | sm;
            m_ovf[i]   = (m_ovf[i] & wdata[14]) | so;
            m_per[i] = wdata[8]; m_ie[i] = wdata[7];
            m_req[i] = wdata[5:4]; m_cks[i] = wdata[2:0];
         end else begin
            m_match[i] = m_match[i] | sm;
            m_ovf[i]   = m_ovf[i] | so;
         end
         if (wr && addr == AW'(base + 2)) m_cmp[i] = wdata;
      end
      if (wr && addr == 0) m_start = wdata[NCH-1:0];
   endtask

   function automatic bit [31:0] model_read(logic [AW-1:0] a);
      bit [31:0] r = 0;
      if (a == 0) r = 32'(m_start);
      for (int i = 0; i < NCH; i++) begin
         if (a == AW'(4 * (i + 1)))
            r = {16'h0, m_match[i], m_ovf[i], 5'h0, m_per[i], m_ie[i], 1'b0, m_req[i], 1'b0, m_cks[i]};
         if (a == AW'(4 * (i + 1) + 1)) r = m_cnt[i];
         if (a == AW'(4 * (i + 1) + 2)) r = m_cmp[i];
      end
      return r;
   endfunction

   function automatic bit model_irq();
      bit r = 0;
      for (int i = 0; i < NCH; i++) r |= m_match[i] && m_ie[i] && (m_req[i] == 2'd2);
      return r;
   endfunction

   function automatic string tag_of(logic [AW-1:0] a);
      case (a % 4)
         0: return (a == 0) ? "R2" : "R7";
         1: return "R8";
         2: return "R10";
         default: return "R2";
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) model_reset();
      else model_step();
   end

   // ---------------- check helpers ----------------
   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   // Every-cycle comparison, 1 ns before the rising edge
   always @(negedge clk) begin
      #1.5;
      if (rst_n && !done) begin
         check(rdata == model_read(addr), tag_of(addr), rdata, model_read(addr));
         check(irq == model_irq(), "R9", 32'(irq), 32'(model_irq()));
      end
   end

   // Reference tick generator and cycle counter
   always @(negedge clk) begin
      cyc++;
      tick <= (tick_period == 1) || (tick_period > 1 && (cyc % tick_period) == 0);
   end

   task automatic bus_write(int a, logic [31:0] d);
      @(negedge clk);
      wr = 1'b1; addr = AW'(a); wdata = d;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd(int a, output logic [31:0] d);
      @(negedge clk);
      addr = AW'(a);
      #1;
      d = rdata;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // Watchdog
   initial begin
      #(5ns * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      logic [31:0] v, v2;
      idle(4);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      rd(0, v);  check(v == 0, "R1 start", v, 0);
      rd(4, v);  check(v == 0, "R1 ctrl0", v, 0);
      rd(5, v);  check(v == 0, "R1 count0", v, 0);
      rd(6, v);  check(v == 32'hFFFF_FFFF, "R1 cmp0", v, 32'hFFFF_FFFF);
      rd(10, v); check(v == 32'hFFFF_FFFF, "R1 cmp1", v, 32'hFFFF_FFFF);
      check(irq == 0, "R1 irq", 32'(irq), 0);

      // R2 unmapped words and start word readback
      rd(3, v);  check(v == 0, "R2 hole3", v, 0);
      rd(7, v);  check(v == 0, "R2 hole7", v, 0);
      bus_write(0, 32'h3);
      rd(0, v);  check(v == 3, "R2 start", v, 3);
      bus_write(0, 32'h0);

      // R10 compare readback
      bus_write(6, 32'd5);
      rd(6, v);  check(v == 5, "R10 cmp0", v, 5);
      bus_write(10, 32'd9);
      rd(10, v); check(v == 9, "R10 cmp1", v, 9);

      // R8 count write lands on the second tick (tick every cycle)
      tick_period = 1;
      bus_write(5, 32'd3);
      rd(5, v);  check(v == 0, "R8 before landing", v, 0);
      rd(5, v);  check(v == 3, "R8 after landing", v, 3);

      // R8 with sparse ticks on channel 1
      tick_period = 4;
      bus_write(9, 32'd100);
      rd(9, v);  check(v == 0, "R8 sparse before", v, 0);
      idle(12);
      rd(9, v);  check(v == 100, "R8 sparse after", v, 100);
      tick_period = 1;

      // R5 periodic match with interrupt request type
      bus_write(4, 32'h01A7);
      bus_write(0, 32'h1);
      idle(20);
      rd(4, v);  check(v[15] == 1, "R5 match flag", v, 32'h81A7);
      rd(5, v);  check(v <= 5, "R5 periodic clear", v, 5);
      check(irq == 1, "R9 irq raised", 32'(irq), 1);

      // R7 write one keeps, write zero clears
      bus_write(0, 32'h0);
      bus_write(4, 32'h81A7);
      rd(4, v);  check(v[15] == 1, "R7 write-one keeps", v, 32'h81A7);
      bus_write(4, 32'h01A7);
      rd(4, v);  check(v == 32'h01A7, "R7 write-zero clears", v, 32'h01A7);
      check(irq == 0, "R9 irq drops", 32'(irq), 0);

      // R9 request type 1 gives no interrupt
      bus_write(4, 32'h0197);
      bus_write(0, 32'h1);
      idle(20);
      rd(4, v);  check(v[15] == 1, "R9 dma match", v, 32'h8197);
      check(irq == 0, "R9 dma no irq", 32'(irq), 0);
      bus_write(0, 32'h0);
      bus_write(4, 32'h0);

      // R6 free-running wrap with overflow (divide by 8)
      bus_write(9, 32'hFFFF_FFF0);
      idle(4);
      bus_write(8, 32'h0004);
      bus_write(0, 32'h2);
      idle(300);
      bus_write(0, 32'h0);
      rd(8, v);  check(v[14] == 1 && v[15] == 1, "R6 ovf and match", v, 32'hC004);
      rd(9, v);  check(v > 9 && v < 100, "R6 runs past compare", v, 32'd20);
      check(irq == 0, "R9 irq disabled", 32'(irq), 0);
      bus_write(8, 32'h0);

      // R3 divide by 32
      bus_write(6, 32'hFFFF_FFFF);
      bus_write(5, 32'd0);
      idle(3);
      bus_write(4, 32'h0005);
      bus_write(0, 32'h1);
      idle(140);
      bus_write(0, 32'h0);
      rd(5, v);  check(v >= 4 && v <= 5, "R3 div32", v, 4);

      // R3 divide by 128
      bus_write(5, 32'd0);
      idle(3);
      bus_write(4, 32'h0006);
      bus_write(0, 32'h1);
      idle(300);
      bus_write(0, 32'h0);
      rd(5, v);  check(v >= 2 && v <= 3, "R3 div128", v, 2);

      // R3 code 2 never advances
      bus_write(4, 32'h0002);
      bus_write(0, 32'h1);
      rd(5, v);
      idle(60);
      rd(5, v2); check(v2 == v, "R3 code2 idle", v2, v);

      // R4 stopped channel holds and stays accessible
      bus_write(4, 32'h0007);
      bus_write(0, 32'h0);
      rd(5, v);
      idle(30);
      rd(5, v2); check(v2 == v, "R4 stopped hold", v2, v);
      bus_write(6, 32'h77);
      rd(6, v);  check(v == 32'h77, "R4 access while stopped", v, 32'h77);

      idle(4);
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule